// File: doc/BRIEF.md
# Serial Test Command Sequencer

This block is the command front end of a built-in self-test routine. It sits behind a serial port that runs as master, and a tester paces that port through a handshake line. After reset the sequencer waits for one command byte. Command zero loads a fixed block of bytes into consecutive RAM locations and then asks the processor to jump to a fixed entry address. The other valid commands start one of several short test functions, which are outside this block. The block drives a busy level and a function select for the active function, and waits for that function's done pulse.

An escape path skips the sequencer completely. If the slave-select input is low when the block leaves reset, it asks for the jump at once and then stays idle for good. Command codes outside the valid set are dropped without any visible effect, and the sequencer keeps waiting for a command.

Top module: `test_cmd_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ram_we`, `jump_req`, `fn_busy` and `byte_ack` are all 0. With `ss_n` high in the first cycle after reset, no jump is requested and the block waits for a command.
- R2: If `ss_n` is low in the first clock cycle after reset, `jump_req` is 1 for exactly one cycle in the next cycle, with `jump_addr` = 13'h05D. After that, no byte is acknowledged and no RAM write occurs until the next reset.
- R3: A byte is taken only when `xfer_done` is 1 and `hs_n` is 0 in the same cycle, and only while the block is waiting for a command or downloading. `byte_ack` is 1 combinationally in that cycle and is 0 at all other times. A `xfer_done` with `hs_n` high has no effect.
- R4: While waiting, a command byte greater than 8'h04 is ignored: no busy, no write and no jump follow, and the next valid command is taken normally.
- R5: Command 8'h00 starts a download. The n-th data byte taken after it (n = 0 to 174) appears one cycle after acceptance as a single-cycle `ram_we`, with `ram_addr` = 8'h50 + n and `ram_wdata` equal to the byte.
- R6: The write of the 175th byte (address 8'hFE) happens in the same cycle as a one-cycle `jump_req` with `jump_addr` = 13'h05D. From then on, no byte is acknowledged, nothing is written and no further jump occurs.
- R7: A command byte from 8'h01 to 8'h04 sets `fn_busy` from the next cycle, with `fn_sel` equal to the code. Both hold until a cycle with `fn_done` = 1. `fn_busy` is 0 from the following cycle, and the block again waits for a command.
- R8: While `fn_busy` is 1, no byte is acknowledged and handshake traffic has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Slave select, sampled in the first cycle after reset |
| hs_n | input | 1 | Tester handshake, low while a transfer is active |
| xfer_done | input | 1 | Serial byte transfer complete flag |
| rx_byte | input | 8 | Byte received by the serial port |
| fn_done | input | 1 | Done pulse from the active test function |
| byte_ack | output | 1 | Byte read; clears the transfer flag |
| fn_busy | output | 1 | A test function is running |
| fn_sel | output | 3 | Code of the running test function |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| jump_req | output | 1 | Request to start execution at jump_addr |
| jump_addr | output | 13 | Execution entry address |

## Verification
The last download byte makes two things happen in the same cycle: the RAM write at 8'hFE and the jump request. A mistake in the end-of-window count would split them into separate cycles or move the jump to the wrong write. The bench streams a 175-byte pattern with irregular gaps and then sends extra bytes after the window. Its reference model expects the write strobe and the jump in one cycle, and every later byte to go unacknowledged. The captured write list is then compared, address by address, with the pattern.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   typedef enum logic [2:0] {
      ST_BOOT = 3'd0,
      ST_IDLE = 3'd1,
      ST_LOAD = 3'd2,
      ST_FUNC = 3'd3,
      ST_GONE = 3'd4
   } tcs_state_e;
endpackage

// File: rtl/tcs_cmd_decode.sv
module tcs_cmd_decode #(
   parameter int DATA_W   = 8,
   parameter int NUM_CMDS = 5,
   localparam int SEL_W   = $clog2(NUM_CMDS)
) (
   input  logic [DATA_W-1:0] code,
   output logic              valid,
   output logic              is_load,
   output logic [SEL_W-1:0]  sel
);
   logic [NUM_CMDS-1:0] hit;

   for (genvar i = 0; i < NUM_CMDS; i++) begin : g_hit
      assign hit[i] = (code == DATA_W'(i));
   end

   assign valid   = |hit;
   assign is_load = hit[0];
   assign sel     = code[SEL_W-1:0];
endmodule

// File: rtl/tcs_load_ctr.sv
module tcs_load_ctr #(
   parameter int LEN   = 175,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (step) cnt <= cnt + 1'b1;
   end

   assign last = (cnt == CNT_W'(LEN - 1));
endmodule

// File: rtl/test_cmd_seq.sv
module test_cmd_seq
   import tcs_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 8,
   parameter int PC_W     = 13,
   parameter int NUM_CMDS = 5,
   parameter int DL_BASE  = 'h50,
   parameter int DL_LEN   = 175,
   parameter int ENTRY    = 'h5D,
   localparam int SEL_W   = $clog2(NUM_CMDS),
   localparam int CNT_W   = $clog2(DL_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_n,
   input  logic              hs_n,
   input  logic              xfer_done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              fn_done,
   output logic              byte_ack,
   output logic              fn_busy,
   output logic [SEL_W-1:0]  fn_sel,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              jump_req,
   output logic [PC_W-1:0]   jump_addr
);
   if (DL_BASE + DL_LEN > (1 << ADDR_W)) begin : g_bad_span
      $error("download window exceeds RAM address space");
   end
   if (NUM_CMDS < 2 || NUM_CMDS > (1 << DATA_W)) begin : g_bad_cmds
      $error("command count out of range");
   end
   if (ENTRY >= (1 << PC_W)) begin : g_bad_entry
      $error("entry address does not fit program counter");
   end

   localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(DL_BASE);
   localparam logic [PC_W-1:0]   ENTRY_V = PC_W'(ENTRY);

   tcs_state_e        state_q;
   logic              take;
   logic              cmd_valid, cmd_load;
   logic [SEL_W-1:0]  cmd_sel;
   logic [CNT_W-1:0]  ld_cnt;
   logic              ld_last;
   logic [SEL_W-1:0]  sel_q;
   logic              we_q, jump_q;
   logic [ADDR_W-1:0] waddr_q;
   logic [DATA_W-1:0] wdata_q;

   assign take = xfer_done & ~hs_n & ((state_q == ST_IDLE) | (state_q == ST_LOAD));

   tcs_cmd_decode #(.DATA_W(DATA_W), .NUM_CMDS(NUM_CMDS)) u_dec (
      .code    (rx_byte),
      .valid   (cmd_valid),
      .is_load (cmd_load),
      .sel     (cmd_sel)
   );

   tcs_load_ctr #(.LEN(DL_LEN), .CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state_q == ST_IDLE),
      .step  (take && state_q == ST_LOAD),
      .cnt   (ld_cnt),
      .last  (ld_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_BOOT;
         sel_q   <= '0;
         we_q    <= 1'b0;
         jump_q  <= 1'b0;
         waddr_q <= '0;
         wdata_q <= '0;
      end else begin
         we_q   <= 1'b0;
         jump_q <= 1'b0;
         case (state_q)
            ST_BOOT: begin
               if (!ss_n) begin
                  jump_q  <= 1'b1;
                  state_q <= ST_GONE;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_IDLE: begin
               if (take && cmd_valid) begin
                  if (cmd_load) begin
                     state_q <= ST_LOAD;
                  end else begin
                     state_q <= ST_FUNC;
                     sel_q   <= cmd_sel;
                  end
               end
            end
            ST_LOAD: begin
               if (take) begin
                  we_q    <= 1'b1;
                  waddr_q <= BASE_V + ADDR_W'(ld_cnt);
                  wdata_q <= rx_byte;
                  if (ld_last) begin
                     jump_q  <= 1'b1;
                     state_q <= ST_GONE;
                  end
               end
            end
            ST_FUNC: begin
               if (fn_done) state_q <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign byte_ack  = take;
   assign fn_busy   = (state_q == ST_FUNC);
   assign fn_sel    = sel_q;
   assign ram_we    = we_q;
   assign ram_addr  = waddr_q;
   assign ram_wdata = wdata_q;
   assign jump_req  = jump_q;
   assign jump_addr = ENTRY_V;
endmodule

// File: rtl/tcs_chk.sv
module tcs_chk #(
   parameter int ADDR_W  = 8,
   parameter int SEL_W   = 3,
   parameter int DL_BASE = 'h50,
   parameter int DL_LEN  = 175
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hs_n,
   input logic              xfer_done,
   input logic              fn_done,
   input logic              byte_ack,
   input logic              fn_busy,
   input logic [SEL_W-1:0]  fn_sel,
   input logic              ram_we,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              jump_req
);
   logic              jumped;
   logic              seen_wr;
   logic [ADDR_W-1:0] prev_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         jumped    <= 1'b0;
         seen_wr   <= 1'b0;
         prev_addr <= '0;
      end else begin
         if (jump_req) jumped <= 1'b1;
         if (ram_we) begin
            seen_wr   <= 1'b1;
            prev_addr <= ram_addr;
         end
      end
   end

   // R3
   ack_needs_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_ack |-> (xfer_done && !hs_n));

   // R5
   wr_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (ram_addr >= ADDR_W'(DL_BASE) &&
                  ram_addr <= ADDR_W'(DL_BASE + DL_LEN - 1)));

   // R5
   wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && seen_wr) |-> (ram_addr == prev_addr + 1'b1));

   // R6
   jump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jump_req |=> !jump_req);

   // R6
   quiet_after_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jumped |-> (!byte_ack && !ram_we && !jump_req));

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_busy && !fn_done) |=> (fn_busy && $stable(fn_sel)));

   // R8
   no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fn_busy |-> !byte_ack);
endmodule

bind test_cmd_seq tcs_chk #(
   .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DL_BASE(DL_BASE), .DL_LEN(DL_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hs_n(hs_n), .xfer_done(xfer_done),
   .fn_done(fn_done), .byte_ack(byte_ack), .fn_busy(fn_busy),
   .fn_sel(fn_sel), .ram_we(ram_we), .ram_addr(ram_addr), .jump_req(jump_req)
);

// File: tb/tb_test_cmd_seq.sv
`timescale 1ns/1ps
module tb_test_cmd_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ss_n = 1'b1;
   logic       hs_n = 1'b1;
   logic       xfer_done = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       fn_done = 1'b0;
   logic       byte_ack, fn_busy, ram_we, jump_req;
   logic [2:0] fn_sel;
   logic [7:0] ram_addr, ram_wdata;
   logic [12:0] jump_addr;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   test_cmd_seq dut (
      .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .hs_n(hs_n),
      .xfer_done(xfer_done), .rx_byte(rx_byte), .fn_done(fn_done),
      .byte_ack(byte_ack), .fn_busy(fn_busy), .fn_sel(fn_sel),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .jump_req(jump_req), .jump_addr(jump_addr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 boot, 1 wait, 2 download, 3 function, 4 finished
   int mst = 0, mcnt = 0, msel = 0;
   int e_we = 0, e_addr = 0, e_data = 0, e_jump = 0;
   int jumps = 0;
   int wr_addr[$];
   int wr_data[$];

   always @(posedge clk) begin
      bit ok;
      ok = xfer_done && !hs_n;
      e_we = 0; e_jump = 0;
      if (!rst_n) begin
         mst = 0; mcnt = 0; msel = 0;
      end else begin
         case (mst)
            0: if (!ss_n) begin e_jump = 1; mst = 4; end else mst = 1;
            1: if (ok && rx_byte < 5) begin
                  if (rx_byte == 0) begin mst = 2; mcnt = 0; end
                  else begin mst = 3; msel = rx_byte; end
               end
            2: if (ok) begin
                  e_we = 1; e_addr = 'h50 + mcnt; e_data = rx_byte;
                  mcnt++;
                  if (mcnt == 175) begin e_jump = 1; mst = 4; end
               end
            3: if (fn_done) mst = 1;
            default: ;
         endcase
      end
      #5;
      chk(ram_we == e_we, "R5 write strobe", ram_we, e_we);
      if (e_we) begin
         chk(ram_addr == e_addr, "R5 write address", ram_addr, e_addr);
         chk(ram_wdata == e_data, "R5 write data", ram_wdata, e_data);
      end
      chk(jump_req == e_jump, "R6 jump strobe", jump_req, e_jump);
      if (e_jump) chk(jump_addr == 13'h05D, "R6 jump target", jump_addr, 'h5D);
      chk(fn_busy == (mst == 3), "R7 busy", fn_busy, mst == 3);
      if (mst == 3) chk(fn_sel == msel, "R7 select", fn_sel, msel);
      chk(byte_ack == (xfer_done && !hs_n && (mst == 1 || mst == 2)),
          "R3 ack", byte_ack, xfer_done && !hs_n && (mst == 1 || mst == 2));
      if (ram_we) begin wr_addr.push_back(ram_addr); wr_data.push_back(ram_wdata); end
      if (jump_req) jumps++;
   end

   task automatic send(input logic [7:0] b, input logic hs = 1'b0, input int gap = 0);
      @(negedge clk);
      rx_byte = b; xfer_done = 1'b1; hs_n = hs;
      @(negedge clk);
      xfer_done = 1'b0; hs_n = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic finish_fn();
      @(negedge clk); fn_done = 1'b1;
      @(negedge clk); fn_done = 1'b0;
   endtask

   task automatic do_reset(input logic ss);
      @(negedge clk); rst_n = 1'b0; ss_n = ss;
      repeat (2) @(negedge clk);
      chk(!ram_we && !jump_req && !fn_busy && !byte_ack, "R1 reset outputs",
          {ram_we, jump_req, fn_busy, byte_ack}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!ram_we && !fn_busy && !byte_ack, "R1 first cycle", {ram_we, fn_busy, byte_ack}, 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      do_reset(1'b1);
      chk(jumps == 0, "R1 no jump with ss_n high", jumps, 0);

      // R3: flag without handshake low is ignored
      send(8'h02, 1'b1, 1);
      chk(!fn_busy, "R3 handshake high ignored", fn_busy, 0);

      // R4: out-of-range codes dropped
      send(8'h07, 1'b0, 1);
      send(8'hFF, 1'b0, 1);
      send(8'h05, 1'b0, 1);
      chk(!fn_busy && wr_addr.size() == 0, "R4 bad code ignored", fn_busy, 0);

      // R7/R8: function commands
      for (int c = 1; c <= 4; c++) begin
         send(8'(c), 1'b0, 0);
         chk(fn_busy && fn_sel == 3'(c), "R7 function start", fn_sel, c);
         send(8'h00, 1'b0, 2);
         chk(fn_busy && wr_addr.size() == 0, "R8 byte during function ignored", fn_busy, 1);
         finish_fn();
         chk(!fn_busy, "R7 function end", fn_busy, 0);
      end

      // R5/R6: download window
      send(8'h00, 1'b0, 1);
      for (int i = 0; i < 175; i++)
         send(8'((i * 37 + 5) & 8'hFF), 1'b0, (i % 7 == 3) ? 2 : 0);
      send(8'h11, 1'b0, 0);
      send(8'h00, 1'b0, 2);
      chk(wr_addr.size() == 175, "R5 write count", wr_addr.size(), 175);
      for (int i = 0; i < wr_addr.size() && i < 175; i++) begin
         chk(wr_addr[i] == 'h50 + i, "R5 address list", wr_addr[i], 'h50 + i);
         chk(wr_data[i] == ((i * 37 + 5) & 'hFF), "R5 data list", wr_data[i], (i * 37 + 5) & 'hFF);
      end
      chk(jumps == 1, "R6 single jump", jumps, 1);

      // R2: slave-select escape
      do_reset(1'b0);
      send(8'h00, 1'b0, 0);
      send(8'h33, 1'b0, 2);
      chk(jumps == 2, "R2 escape jump", jumps, 2);
      chk(wr_addr.size() == 175, "R2 no writes after escape", wr_addr.size(), 175);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule